// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds an 8-bit control register that a small processor writes to move itself out of normal running and into one of three reduced-power states: sleep, stop, or a timer-only state in which only the time-base timer keeps running. The same register also controls two more things. A write can fire a short internal reset pulse. A two-bit field throttles the CPU clock by gating it off for a fixed number of clocks after every machine-cycle strobe.

Several bits act only when they are written with one particular value. Writing the opposite value leaves everything as it was. A wake-up interrupt returns the block to normal running. A pin-control bit decides whether the external pins float or hold their level while the block is in stop or timer-only state. The oscillator, the clock dividers, the time-base timer and the pin drivers are not part of this block. They see only the flags and enables that it drives.

Top module: `lpm_ctrl`

## Requirements
- R1: After synchronous reset, rd_data reads 0x08, no mode flag is set, cpu_clk_en is 1, pins_hiz is 0 and int_rst is 0.
- R2: rd_data bits 7, 6, 4 and 0 always read 0. Bit 5 returns the stored pin-float bit, and bits 2:1 return the stored throttle field. Bit 3 reads 0 only while the timer-only mode is active, and 1 otherwise. A 1 written to bit 0 is ignored.
- R3: A write with bit 7 = 1 enters stop mode (stop_o = 1) from the next cycle on. A write with bit 7 = 0 does not enter stop.
- R4: A write with bit 6 = 1 enters sleep mode (sleep_o = 1). A write with bit 6 = 0 does not enter sleep.
- R5: A write with bit 3 = 0 enters timer-only mode (tbt_o = 1). A write with bit 3 = 1 does not enter it.
- R6: When a single write requests several modes, stop wins over timer-only, and timer-only wins over sleep. At most one mode flag is ever set.
- R7: A write with bit 4 = 0 drives int_rst high for exactly 3 clock cycles, starting in the cycle after the write. A write with bit 4 = 1 produces no pulse.
- R8: pins_hiz equals the stored bit 5 while in stop or timer-only mode, and is 0 in run and sleep.
- R9: In any low-power mode, wake_irq = 1 returns the block to run on the next cycle: all flags clear and cpu_clk_en is 1.
- R10: In run mode, a machine-cycle strobe (mcyc) drops cpu_clk_en for a number of clocks set by bits 2:1: 00 gives 0 clocks, 01 gives 8, 10 gives 16 and 11 gives 32. The drop starts in the cycle after the strobe.
- R11: A strobe that arrives while the clock is halted is ignored and does not lengthen the halt.
- R12: cpu_clk_en is 0 whenever sleep, stop or timer-only mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| mcyc | input | 1 | Machine-cycle strobe |
| wake_irq | input | 1 | Wake-up interrupt request |
| sleep_o | output | 1 | Sleep mode active |
| stop_o | output | 1 | Stop mode active |
| tbt_o | output | 1 | Timer-only mode active |
| cpu_clk_en | output | 1 | CPU clock enable |
| pins_hiz | output | 1 | External pins to high impedance |
| int_rst | output | 1 | Internal reset pulse |

## Verification
The assertions check these rules on every cycle:
- the mode flags are mutually exclusive;
- the CPU clock is gated in every low-power mode;
- pins float only in stop or timer-only mode;
- the reserved and write-only read bits stay 0;
- a wake request always returns the block to run;
- a stop request or a reset-bit write always takes effect one cycle later.

Only the bench scenarios can show the rest:
- the exact priority when a single write requests several modes;
- the read-back of bit 3 and bit 5 across modes;
- the exact three-cycle reset pulse length;
- the 0, 8, 16 and 32 clock halt lengths, and that a strobe arriving during a halt does not stretch it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_STOP  = 2'd2,
        MODE_TBT   = 2'd3
    } lpm_mode_e;

    // Bit layout of a register write, bit 7 first.
    typedef struct packed {
        logic       stop_req;   // 1 enters stop
        logic       sleep_req;  // 1 enters sleep
        logic       pin_float;  // pins float in stop / timer-only
        logic       rst_keep;   // 0 fires reset pulse
        logic       tbt_keep;   // 0 enters timer-only mode
        logic [1:0] throttle;   // halt length select
        logic       rsvd;       // ignored
    } lpm_wr_t;

    function automatic lpm_mode_e pick_mode(lpm_wr_t w, lpm_mode_e cur);
        if (w.stop_req)       return MODE_STOP;
        else if (!w.tbt_keep) return MODE_TBT;
        else if (w.sleep_req) return MODE_SLEEP;
        else                  return cur;
    endfunction

    function automatic int unsigned halt_cycles(logic [1:0] sel, int unsigned unit);
        case (sel)
            2'b00:   return 0;
            2'b01:   return unit;
            2'b10:   return 2 * unit;
            default: return 4 * unit;
        endcase
    endfunction

endpackage

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  lpm_wr_t    wr_fields,
    output logic       pin_float_q,
    output logic [1:0] throttle_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_float_q <= 1'b0;
            throttle_q  <= 2'b00;
        end else if (wr_en) begin
            pin_float_q <= wr_fields.pin_float;
            throttle_q  <= wr_fields.throttle;
        end
    end
endmodule

// File: rtl/lpm_mode_seq.sv
module lpm_mode_seq
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  lpm_wr_t   wr_fields,
    input  logic      wake_irq,
    output lpm_mode_e mode_q
);
    lpm_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wake_irq && mode_q != MODE_RUN)
            mode_d = MODE_RUN;
        else if (wr_en)
            mode_d = pick_mode(wr_fields, mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RUN;
        else     mode_q <= mode_d;
    end
endmodule

// File: rtl/lpm_rst_pulse.sv
module lpm_rst_pulse #(
    parameter int unsigned RST_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int RW = $clog2(RST_LEN + 1);
    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (fire)        cnt_q <= RW'(RST_LEN);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/lpm_throttle.sv
module lpm_throttle
    import lpm_pkg::*;
#(
    parameter int unsigned HALT_UNIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       mcyc,
    input  logic [1:0] sel,
    output logic       halted
);
    localparam int CW = $clog2(4 * HALT_UNIT + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
        else if (mcyc)
            cnt_q <= CW'(halt_cycles(sel, HALT_UNIT));
    end

    assign halted = (cnt_q != '0);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int unsigned HALT_UNIT = 8,
    parameter int unsigned RST_LEN   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       mcyc,
    input  logic       wake_irq,
    output logic       sleep_o,
    output logic       stop_o,
    output logic       tbt_o,
    output logic       cpu_clk_en,
    output logic       pins_hiz,
    output logic       int_rst
);
    lpm_wr_t   wr_fields;
    lpm_mode_e mode;
    logic      pin_float;
    logic [1:0] throttle;
    logic      halted;
    logic      run;

    assign wr_fields = lpm_wr_t'(wr_data);

    lpm_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_fields(wr_fields),
        .pin_float_q(pin_float), .throttle_q(throttle)
    );

    lpm_mode_seq u_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_fields(wr_fields),
        .wake_irq(wake_irq), .mode_q(mode)
    );

    lpm_rst_pulse #(.RST_LEN(RST_LEN)) u_rstp (
        .clk(clk), .rst(rst), .fire(wr_en && !wr_fields.rst_keep),
        .pulse(int_rst)
    );

    assign run = (mode == MODE_RUN);

    lpm_throttle #(.HALT_UNIT(HALT_UNIT)) u_thr (
        .clk(clk), .rst(rst), .run(run), .mcyc(mcyc), .sel(throttle),
        .halted(halted)
    );

    assign sleep_o    = (mode == MODE_SLEEP);
    assign stop_o     = (mode == MODE_STOP);
    assign tbt_o      = (mode == MODE_TBT);
    assign cpu_clk_en = run && !halted;
    assign pins_hiz   = pin_float && (stop_o || tbt_o);
    assign rd_data    = {2'b00, pin_float, 1'b0, !tbt_o, throttle, 1'b0};
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       wake_irq,
    input logic       sleep_o,
    input logic       stop_o,
    input logic       tbt_o,
    input logic       cpu_clk_en,
    input logic       pins_hiz,
    input logic       int_rst
);
    logic lowpwr;
    assign lowpwr = sleep_o || stop_o || tbt_o;

    assert_clk_gated_R12: assert property (@(posedge clk) disable iff (rst)
        lowpwr |-> !cpu_clk_en);

    assert_one_mode_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sleep_o, stop_o, tbt_o}));

    assert_hiz_scope_R8: assert property (@(posedge clk) disable iff (rst)
        pins_hiz |-> (stop_o || tbt_o));

    assert_wake_R9: assert property (@(posedge clk) disable iff (rst)
        (wake_irq && lowpwr) |=> (!sleep_o && !stop_o && !tbt_o && cpu_clk_en));

    assert_stop_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7] && !(wake_irq && lowpwr)) |=> stop_o);

    assert_rst_fire_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[4]) |=> int_rst);

    assert_zero_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_data[7:6] == 2'b00) && !rd_data[4] && !rd_data[0]);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wake_irq(wake_irq), .sleep_o(sleep_o), .stop_o(stop_o), .tbt_o(tbt_o),
    .cpu_clk_en(cpu_clk_en), .pins_hiz(pins_hiz), .int_rst(int_rst)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       mcyc;
    logic       wake_irq;
    logic       sleep_o, stop_o, tbt_o, cpu_clk_en, pins_hiz, int_rst;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lpm_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .mcyc(mcyc), .wake_irq(wake_irq), .sleep_o(sleep_o), .stop_o(stop_o),
        .tbt_o(tbt_o), .cpu_clk_en(cpu_clk_en), .pins_hiz(pins_hiz), .int_rst(int_rst)
    );

    // {write data, expected read, {sleep,stop,tbt}, pins_hiz}
    localparam logic [19:0] VEC [12] = '{
        {8'h18, 8'h08, 3'b000, 1'b0},   // R3 R4 R5: no request
        {8'h58, 8'h08, 3'b100, 1'b0},   // R4 sleep
        {8'h98, 8'h08, 3'b010, 1'b0},   // R3 stop, pins hold
        {8'hB8, 8'h28, 3'b010, 1'b1},   // R8 stop, pins float
        {8'h30, 8'h20, 3'b001, 1'b1},   // R5 timer-only, float
        {8'h10, 8'h00, 3'b001, 1'b0},   // R5 timer-only, hold
        {8'h78, 8'h28, 3'b100, 1'b0},   // R8 sleep never floats
        {8'hD8, 8'h08, 3'b010, 1'b0},   // R6 stop over sleep
        {8'h50, 8'h00, 3'b001, 1'b0},   // R6 timer over sleep
        {8'hD0, 8'h08, 3'b010, 1'b0},   // R6 stop over all
        {8'h1F, 8'h0E, 3'b000, 1'b0},   // R2 reserved ignored
        {8'h19, 8'h08, 3'b000, 1'b0}    // R2 reserved ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h18;
    endtask

    task automatic wake();
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
    endtask

    task automatic measure_halt(input logic [1:0] sel, input bit mid, output int n);
        wr({3'b000, 2'b11, sel, 1'b0});
        mcyc = 1'b1;
        @(negedge clk);
        mcyc = 1'b0;
        n = 0;
        while (!cpu_clk_en && n < 100) begin
            mcyc = (mid && n == 3);
            n++;
            @(negedge clk);
        end
        mcyc = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int highs;
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h18; mcyc = 1'b0; wake_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rd", rd_data, 8'h08);
        check("R1 flags", {sleep_o, stop_o, tbt_o}, 3'b000);
        check("R1 clk_en", cpu_clk_en, 1'b1);
        check("R1 hiz", pins_hiz, 1'b0);
        check("R1 int_rst", int_rst, 1'b0);

        // vector walk
        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][19:12]);
            check("R2 rd", rd_data, VEC[i][11:4]);
            check("R3 R4 R5 R6 flags", {sleep_o, stop_o, tbt_o}, VEC[i][3:1]);
            check("R8 hiz", pins_hiz, VEC[i][0]);
            check("R12 clk_en", cpu_clk_en, VEC[i][3:1] == 3'b000);
            check("R7 no pulse", int_rst, 1'b0);
            wake();
            check("R9 wake flags", {sleep_o, stop_o, tbt_o}, 3'b000);
            check("R9 wake clk_en", cpu_clk_en, 1'b1);
        end

        // R7 reset pulse length
        wr(8'h08);
        highs = 0;
        check("R7 first cycle", int_rst, 1'b1);
        for (int k = 0; k < 6; k++) begin
            if (int_rst) highs++;
            @(negedge clk);
        end
        check("R7 pulse length", highs, 3);
        check("R7 mode untouched", {sleep_o, stop_o, tbt_o}, 3'b000);

        // R10 halt lengths
        measure_halt(2'b00, 1'b0, n);
        check("R10 sel00", n, 0);
        measure_halt(2'b01, 1'b0, n);
        check("R10 sel01", n, 8);
        measure_halt(2'b10, 1'b0, n);
        check("R10 sel10", n, 16);
        measure_halt(2'b11, 1'b0, n);
        check("R10 sel11", n, 32);

        // R11 strobe during halt ignored
        measure_halt(2'b01, 1'b1, n);
        check("R11 no stretch", n, 8);
        @(negedge clk);
        check("R11 stays enabled", cpu_clk_en, 1'b1);

        // R9 wake in run mode changes nothing
        wake();
        check("R9 run wake", {sleep_o, stop_o, tbt_o, cpu_clk_en}, 4'b0001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule